// File: doc/BRIEF.md
# Burst-Capable Local Bus Target

This block is a synchronous slave on a 32-bit local bus with separate address and data lines, driven by a PCI bridge. The master starts a transfer by pulling an active-low address strobe low. On that clock edge the block latches the word address and the transfer direction. It answers only when address bit 23 is zero, which gives it an 8-Mbyte window without a full address compare. Once a transfer is accepted, it paces each data beat with an active-low ready. The master marks the final beat with an active-low last-beat strobe.

Behind the bus sits a small internal word array. Write beats update only the byte lanes whose active-low enable is low. Read beats return the addressed word on the bidirectional data bus, and the block drives that bus only during a read beat. The word index starts at the low address bits and steps by one after every beat, wrapping at the array depth. A burst longer than `MAX_BEATS` is cut short with an active-low burst-terminate, so the master must start a new transfer to continue. Ready and burst-terminate are released to high impedance whenever no transfer is in progress.

Top module: `lbus_target`

## Requirements
- R1: During reset and in idle, ready and burst-terminate are high impedance, the data bus is not driven, and every array word reads as zero after reset.
- R2: An address strobe with address bit 23 high is ignored: ready stays released and no array word changes.
- R3: With address bit 23 low, ready goes low in the clock after the address-strobe edge and stays low on every clock of the transfer.
- R4: On a write beat, byte lane b (data bits 8b+7..8b) of the addressed word is updated exactly when byte-enable bit b is low.
- R5: The data bus is driven with the addressed word only during read beats; during write beats and idle it is released.
- R6: The first beat uses word index address[log2(DEPTH)+1:2]; each completed beat advances the index by one modulo DEPTH.
- R7: A beat completed with the last-beat strobe low ends the transfer; ready is released in the next clock.
- R8: On beat number MAX_BEATS (default 8) without the last-beat strobe, burst-terminate is driven low together with ready and the transfer ends; on every other beat it is driven high.
- R9: The direction is taken only at the address-strobe edge; changes of the direction input during the beats have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low reset from the bridge |
| addr_i | input | 30 | Word address, bits 31..2 |
| be_n_i | input | 4 | Active-low byte-lane enables |
| wr_i | input | 1 | High for write, low for read |
| ads_n_i | input | 1 | Active-low address strobe |
| blast_n_i | input | 1 | Active-low last-beat strobe |
| data_io | inout | 32 | Bidirectional data bus |
| ready_n_o | output | 1 | Active-low beat ready, tri-stated when idle |
| bterm_n_o | output | 1 | Active-low burst terminate, tri-stated when idle |

## Verification
The transfer is accepted at the address-strobe edge, so ready and read data appear in the next clock. Both are combinational from the beat state, so they are due in the same clock as each later beat. A write takes effect at the edge that ends its beat and shows up only on a later read beat. The release of ready is due one clock after the beat marked last or terminated. The bench drives inputs just after each rising edge and compares ready, burst-terminate and the data bus against its own model at every falling edge. This places each comparison in the clock where the result is due.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  typedef enum logic {ST_IDLE, ST_BEAT} lbt_state_e;

  // Merge new data into an old word, taking only lanes whose enable is low.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be_n);
    logic [31:0] res;
    res = old_w;
    for (int b = 0; b < 4; b++) begin
      if (!be_n[b]) res[8*b +: 8] = new_w[8*b +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/lbt_decode.sv
module lbt_decode #(
  parameter int WIN_BIT = 23,
  parameter int IW      = 4
) (
  input  logic [31:2]   addr_i,
  input  logic          ads_n_i,
  output logic          hit_o,
  output logic [IW-1:0] start_idx_o
);
  logic unused_addr;

  assign hit_o       = !ads_n_i && !addr_i[WIN_BIT];
  assign start_idx_o = addr_i[IW+1:2];
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
  import lbt_pkg::*;
#(
  parameter int IW        = 4,
  parameter int MAX_BEATS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          wr_i,
  input  logic [IW-1:0] start_idx_i,
  input  logic          blast_n_i,
  output logic          active_o,
  output logic          wr_q_o,
  output logic [IW-1:0] ptr_o,
  output logic          done_o,
  output logic          term_o
);
  localparam int CW = $clog2(MAX_BEATS + 1);

  lbt_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign active_o = (state_q == ST_BEAT);
  assign at_limit = (cnt_q == CW'(MAX_BEATS - 1));
  assign done_o   = active_o && (!blast_n_i || at_limit);
  assign term_o   = active_o && blast_n_i && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ptr_o   <= '0;
      wr_q_o  <= 1'b0;
    end else if (!active_o) begin
      if (hit_i) begin
        state_q <= ST_BEAT;
        cnt_q   <= '0;
        ptr_o   <= start_idx_i;
        wr_q_o  <= wr_i;
      end
    end else begin
      ptr_o <= ptr_o + 1'b1;
      cnt_q <= cnt_q + 1'b1;
      if (done_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/lbt_array.sv
module lbt_array
  import lbt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    be_n_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [DEPTH];

  assign rdata_o = mem_q[idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= lane_merge(mem_q[idx_i], wdata_i, be_n_i);
    end
  end
endmodule

// File: rtl/lbus_target.sv
module lbus_target #(
  parameter int DEPTH     = 16,
  parameter int MAX_BEATS = 8,
  parameter int WIN_BIT   = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:2] addr_i,
  input  logic [3:0]  be_n_i,
  input  logic        wr_i,
  input  logic        ads_n_i,
  input  logic        blast_n_i,
  inout  wire  [31:0] data_io,
  output wire         ready_n_o,
  output wire         bterm_n_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          hit;
  logic [IW-1:0] start_idx;
  logic          active;
  logic          wr_q;
  logic [IW-1:0] ptr;
  logic          done;
  logic          term;
  logic          rd_oe;
  logic          wr_beat;
  logic [31:0]   rdata;

  lbt_decode #(.WIN_BIT(WIN_BIT), .IW(IW)) u_dec (
    .addr_i(addr_i), .ads_n_i(ads_n_i), .hit_o(hit), .start_idx_o(start_idx)
  );

  lbt_ctrl #(.IW(IW), .MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .wr_i(wr_i),
    .start_idx_i(start_idx), .blast_n_i(blast_n_i),
    .active_o(active), .wr_q_o(wr_q), .ptr_o(ptr),
    .done_o(done), .term_o(term)
  );

  assign rd_oe   = active && !wr_q;
  assign wr_beat = active && wr_q;

  lbt_array #(.DEPTH(DEPTH), .IW(IW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we_i(wr_beat), .idx_i(ptr),
    .wdata_i(data_io), .be_n_i(be_n_i), .rdata_o(rdata)
  );

  assign data_io   = rd_oe  ? rdata   : 32'bz;
  assign ready_n_o = active ? 1'b0    : 1'bz;
  assign bterm_n_o = active ? !term   : 1'bz;
endmodule

// File: rtl/lbus_target_chk.sv
module lbus_target_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ads_n,
  input logic          win_hi,
  input logic          blast_n,
  input logic          hit,
  input logic          active,
  input logic          done,
  input logic          term,
  input logic          wr_q,
  input logic          rd_oe,
  input logic [IW-1:0] ptr
);
  // R2
  miss_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ads_n && win_hi) |=> !active);
  // R3
  open_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && hit) |=> active);
  // R5
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (active && !wr_q));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> (ptr == IW'($past(ptr) + 1'b1)));
  // R7
  last_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !blast_n) |=> !active);
  // R8
  term_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> blast_n);
  // R8
  term_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !active);
  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(wr_q));
endmodule

bind lbus_target lbus_target_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n_i), .win_hi(addr_i[WIN_BIT]),
  .blast_n(blast_n_i), .hit(hit), .active(active), .done(done),
  .term(term), .wr_q(wr_q), .rd_oe(rd_oe), .ptr(ptr)
);

// File: tb/lbus_target_tb_top.sv
module lbus_target_tb_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int MAXB   = 8;
  localparam logic [31:0] IDLE_PAT = 32'hA5A5_5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:2] addr = '0;
  logic [3:0]  be_n = 4'hF;
  logic        wr = 1'b0;
  logic        ads_n = 1'b1;
  logic        blast_n = 1'b1;
  logic        tb_oe = 1'b1;
  logic [31:0] tb_dat = IDLE_PAT;

  wire [31:0] data_w;
  wire        ready_w;
  wire        bterm_w;

  assign data_w = tb_oe ? tb_dat : 32'bz;
  pullup (ready_w);
  pullup (bterm_w);

  int          errs = 0;
  int          checks = 0;
  bit          finished = 0;
  logic [31:0] mdl [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  lbus_target dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .be_n_i(be_n), .wr_i(wr),
    .ads_n_i(ads_n), .blast_n_i(blast_n), .data_io(data_w),
    .ready_n_o(ready_w), .bterm_n_o(bterm_w)
  );

  function automatic logic [31:0] patt(input int k);
    return (32'(k) * 32'h0103_0507) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare one cycle at the falling edge, then move past the next rising edge.
  task automatic look(input string tag, input bit busy, input bit term,
                      input bit rd, input logic [31:0] rexp);
    @(negedge clk);
    chk(tag, "ready", {31'b0, ready_w}, {31'b0, !busy});
    chk(tag, "bterm", {31'b0, bterm_w}, {31'b0, !(busy && term)});
    chk(tag, "data",  data_w, rd ? rexp : tb_dat);
    @(posedge clk);
    #1;
  endtask

  task automatic burst(input string tag, input bit w, input int widx,
                       input bit outside, input int n, input logic [3:0] be,
                       input bit flip, input int seed);
    int beats;
    int st;
    beats = (n > MAXB) ? MAXB : n;
    st = widx % DEPTH;
    addr = '0;
    addr[9:2] = widx[7:0];
    addr[23] = outside;
    addr[28] = 1'b1;
    ads_n = 1'b0;
    wr = w;
    tb_oe = 1'b1;
    tb_dat = IDLE_PAT;
    look(tag, 1'b0, 1'b0, 1'b0, '0);
    ads_n = 1'b1;
    addr = '1;
    for (int i = 0; i < beats; i++) begin
      int ix;
      bit rd;
      ix = (st + i) % DEPTH;
      rd = !outside && !w;
      blast_n = (i == n - 1) ? 1'b0 : 1'b1;
      be_n = be;
      wr = flip ? !w : w;
      tb_oe = !rd;
      tb_dat = w ? patt(seed + i) : IDLE_PAT;
      // R3 ready on each beat, R5 data only on reads, R8 terminate position
      look(tag, !outside, (i == MAXB - 1) && (i != n - 1), rd, mdl[ix]);
      if (w && !outside) begin
        for (int b = 0; b < 4; b++)
          if (!be[b]) mdl[ix][8*b +: 8] = tb_dat[8*b +: 8];
      end
    end
    blast_n = 1'b1;
    be_n = 4'hF;
    wr = 1'b0;
    tb_oe = 1'b1;
    tb_dat = IDLE_PAT;
    addr = '0;
    // R7: released in the clock after the closing beat
    look(tag, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    #1;
    // R1 reset state
    look("R1", 1'b0, 1'b0, 1'b0, '0);
    look("R1", 1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    look("R1", 1'b0, 1'b0, 1'b0, '0);
    burst("R1 read zero", 1'b0, 7, 1'b0, 1, 4'h0, 1'b0, 0);
    burst("R4 full write", 1'b1, 3, 1'b0, 1, 4'b0000, 1'b0, 10);
    burst("R5 read", 1'b0, 3, 1'b0, 1, 4'h0, 1'b0, 0);
    burst("R6 wrap write", 1'b1, 14, 1'b0, 4, 4'b0000, 1'b0, 20);
    burst("R6 wrap read", 1'b0, 30, 1'b0, 4, 4'h0, 1'b0, 0);
    burst("R4 lanes write", 1'b1, 3, 1'b0, 1, 4'b1010, 1'b0, 40);
    burst("R4 lanes read", 1'b0, 3, 1'b0, 1, 4'h0, 1'b0, 0);
    burst("R2 outside write", 1'b1, 5, 1'b1, 2, 4'b0000, 1'b0, 50);
    burst("R2 outside read", 1'b0, 5, 1'b1, 2, 4'h0, 1'b0, 0);
    burst("R2 check", 1'b0, 5, 1'b0, 2, 4'h0, 1'b0, 0);
    burst("R8 long write", 1'b1, 5, 1'b0, 10, 4'b0000, 1'b0, 60);
    burst("R8 long read", 1'b0, 5, 1'b0, 11, 4'h0, 1'b0, 0);
    burst("R8 exact read", 1'b0, 2, 1'b0, MAXB, 4'h0, 1'b0, 0);
    burst("R9 flip write", 1'b1, 9, 1'b0, 3, 4'b0000, 1'b1, 80);
    burst("R9 flip read", 1'b0, 9, 1'b0, 3, 4'h0, 1'b1, 0);
    burst("R7 short read", 1'b0, 0, 1'b0, 2, 4'h0, 1'b0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule